// File: doc/BRIEF.md
# Register-Space ALU with Flag Update

This block is the 8-bit arithmetic and logic stage for instructions whose operands live in register-space memory. For each operation it takes the current value of the destination register and a second operand. The second operand is either a source register value or an immediate byte, picked by a select bit. The block then produces the byte to be written back, a write strobe for the destination, and the updated sign, zero and carry flags.

The flags live inside the block. The carry input of add-with-carry and subtract-with-carry is the block's own carry flag, so chained multi-byte arithmetic works without outside help. Register storage and operand fetch belong to the surrounding core. The surrounding core presents one operation per cycle with a valid strobe, and the results appear one clock later.

Each operation follows fixed rules that decide which flags change and whether the destination is written. Compare and test-mask only set flags. Bitwise operations never touch carry. Every subtract-type operation reports a borrow by setting carry to 1.

Top module: `rs_alu`

## Requirements
- R1: Operation codes on `op_code`: 0 ADD, 1 ADC, 2 SUB, 3 SUBC, 4 CP, 5 INC, 6 DEC, 7 AND, 8 TM, 9 OR, 10 XOR. ADD gives dest+opnd. ADC gives dest+opnd+C. SUB and CP give dest−opnd. SUBC gives dest−opnd−C. AND/TM, OR and XOR give the bitwise result. All results are taken modulo 256.
- R2: The second operand is `imm_val` when `use_imm` is 1 and `src_val` when it is 0. INC computes dest+1 and DEC computes dest−1; both ignore `use_imm`, `src_val` and `imm_val`.
- R3: An operation presented with `op_valid` high at a rising edge shows on `res_o` and the flags right after that edge. `wr_en_o` is high for exactly that one cycle and low in any cycle that follows an edge without a valid legal operation.
- R4: `wr_en_o` is set for every legal operation except CP and TM. For CP and TM, `res_o` still shows the computed value.
- R5: After every legal operation, `sign_o` equals bit 7 of the result and `zero_o` is 1 exactly when the result is 0x00.
- R6: ADD and ADC set carry to the carry out of bit 7. SUB, SUBC and CP set carry to 1 when a borrow occurs and to 0 otherwise. SUBC treats an incoming carry of 1 as an extra borrow.
- R7: INC sets carry only when wrapping from 0xFF to 0x00. DEC sets carry only when wrapping from 0x00 to 0xFF.
- R8: AND, TM, OR and XOR leave the carry flag unchanged.
- R9: Codes 11 to 15 and idle cycles produce no write and leave `res_o`, `sign_o`, `zero_o` and `carry_o` unchanged.
- R10: Reset asserts asynchronously on `rst_n` low and is released on the second clock edge after `rst_n` rises. In reset, `res_o`=0x00, `wr_en_o`=0, sign=0, zero=1 and carry=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select, encoding in R1 |
| use_imm | input | 1 | 1 selects the immediate as second operand |
| dest_val | input | 8 | Current destination register value |
| src_val | input | 8 | Source register value |
| imm_val | input | 8 | Immediate operand |
| res_o | output | 8 | Registered result |
| wr_en_o | output | 1 | Destination write strobe, one cycle |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry/borrow flag |

## Verification
Because the flag register feeds ADC and SUBC, a wrong carry does not stay hidden. It shows on `carry_o` one cycle after the faulty operation, and it corrupts the next carry-consuming result one operation later. The vector sequence is therefore ordered so that carry-preserving bitwise operations sit between carry producers and carry consumers. A wrong write-enable decode shows on `wr_en_o` in the cycle right after the compare or test-mask. A stale or misrouted operand shows in `res_o` on that same cycle.

// File: rtl/rs_alu_pkg.sv
package rs_alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD  = 4'd0,
    ALU_ADC  = 4'd1,
    ALU_SUB  = 4'd2,
    ALU_SUBC = 4'd3,
    ALU_CP   = 4'd4,
    ALU_INC  = 4'd5,
    ALU_DEC  = 4'd6,
    ALU_AND  = 4'd7,
    ALU_TM   = 4'd8,
    ALU_OR   = 4'd9,
    ALU_XOR  = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic sgn;
    logic zer;
    logic cry;
  } alu_flags_t;

endpackage

// File: rtl/rs_alu_opsel.sv
module rs_alu_opsel #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] imm_val,
  output logic [DATA_W-1:0] opnd_b
);

  always_comb begin
    if (use_imm) opnd_b = imm_val;
    else         opnd_b = src_val;
  end

endmodule

// File: rtl/rs_alu_core.sv
module rs_alu_core
  import rs_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              cin,
  output logic [DATA_W-1:0] result,
  output logic              cout
);

  localparam int unsigned EXT_W = DATA_W + 1;
  localparam logic [EXT_W-1:0] ONE_X = {{DATA_W{1'b0}}, 1'b1};

  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [EXT_W-1:0] ext_c;
  logic [EXT_W-1:0] wide;

  always_comb begin
    ext_a = {1'b0, opnd_a};
    ext_b = {1'b0, opnd_b};
    ext_c = {{DATA_W{1'b0}}, cin};
    case (op)
      ALU_ADD:         wide = ext_a + ext_b;
      ALU_ADC:         wide = ext_a + ext_b + ext_c;
      ALU_SUB, ALU_CP: wide = ext_a - ext_b;
      ALU_SUBC:        wide = ext_a - ext_b - ext_c;
      ALU_INC:         wide = ext_a + ONE_X;
      ALU_DEC:         wide = ext_a - ONE_X;
      ALU_AND, ALU_TM: wide = {1'b0, opnd_a & opnd_b};
      ALU_OR:          wide = {1'b0, opnd_a | opnd_b};
      ALU_XOR:         wide = {1'b0, opnd_a ^ opnd_b};
      default:         wide = ext_a;
    endcase
    result = wide[DATA_W-1:0];
    cout   = wide[DATA_W];
  end

endmodule

// File: rtl/rs_alu_flagctl.sv
module rs_alu_flagctl
  import rs_alu_pkg::*;
(
  input  logic            op_valid,
  input  logic [OP_W-1:0] op,
  output logic            commit,
  output logic            wr_dest,
  output logic            upd_carry
);

  logic legal;

  always_comb begin
    legal     = 1'b0;
    wr_dest   = 1'b0;
    upd_carry = 1'b0;
    case (op)
      ALU_ADD, ALU_ADC, ALU_SUB, ALU_SUBC, ALU_INC, ALU_DEC: begin
        legal     = 1'b1;
        wr_dest   = 1'b1;
        upd_carry = 1'b1;
      end
      ALU_CP: begin
        legal     = 1'b1;
        upd_carry = 1'b1;
      end
      ALU_TM: begin
        legal = 1'b1;
      end
      ALU_AND, ALU_OR, ALU_XOR: begin
        legal   = 1'b1;
        wr_dest = 1'b1;
      end
      default: begin
        legal = 1'b0;
      end
    endcase
    commit = op_valid & legal;
  end

endmodule

// File: rtl/rs_alu.sv
module rs_alu
  import rs_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] dest_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] imm_val,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic              sign_o,
  output logic              zero_o,
  output logic              carry_o
);

  localparam int unsigned SYNC_D = 2;

  // reset: asynchronous assert, synchronous release
  logic [SYNC_D-1:0] rst_pipe_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_D-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_D-1];

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;
  logic              alu_cout;
  logic              commit, wr_dest, upd_carry;

  rs_alu_opsel #(.DATA_W(DATA_W)) u_opsel (
    .use_imm (use_imm),
    .src_val (src_val),
    .imm_val (imm_val),
    .opnd_b  (opnd_b)
  );

  rs_alu_core #(.DATA_W(DATA_W)) u_core (
    .op     (op_code),
    .opnd_a (dest_val),
    .opnd_b (opnd_b),
    .cin    (carry_o),
    .result (alu_res),
    .cout   (alu_cout)
  );

  rs_alu_flagctl u_flagctl (
    .op_valid  (op_valid),
    .op        (op_code),
    .commit    (commit),
    .wr_dest   (wr_dest),
    .upd_carry (upd_carry)
  );

  // next state
  alu_flags_t        flags_q, flags_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              we_q, we_d;

  always_comb begin
    flags_d = flags_q;
    res_d   = res_q;
    we_d    = 1'b0;
    if (commit) begin
      res_d       = alu_res;
      we_d        = wr_dest;
      flags_d.sgn = alu_res[DATA_W-1];
      flags_d.zer = (alu_res == '0);
      if (upd_carry) flags_d.cry = alu_cout;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q   <= '0;
      we_q    <= 1'b0;
      flags_q <= '{sgn: 1'b0, zer: 1'b1, cry: 1'b0};
    end else begin
      we_q <= we_d;
      if (commit) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign res_o   = res_q;
  assign wr_en_o = we_q;
  assign sign_o  = flags_q.sgn;
  assign zero_o  = flags_q.zer;
  assign carry_o = flags_q.cry;

  // R4
  no_cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && (op_code == ALU_CP || op_code == ALU_TM)) |=> !wr_en_o);

  // R8
  logic_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && (op_code == ALU_AND || op_code == ALU_TM ||
                  op_code == ALU_OR  || op_code == ALU_XOR)) |=> $stable(carry_o));

  // R5
  zero_track_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    zero_o == (res_o == '0));

  // R5
  sign_track_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sign_o == res_o[DATA_W-1]);

  // R9
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op_code > ALU_XOR) |=>
      (!wr_en_o && $stable(res_o) && $stable(carry_o) && $stable(zero_o)));

  // R3
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !op_valid |=> !wr_en_o);

  // R7
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op_code == ALU_INC && dest_val == {DATA_W{1'b1}}) |=>
      (carry_o && zero_o));

endmodule

// File: tb/rs_alu_tb.sv
`timescale 1ns/1ps
module rs_alu_tb;

  typedef struct packed {
    logic [3:0] op;
    logic       imm;
    logic [7:0] d;
    logic [7:0] s;
    logic [7:0] i;
    logic [7:0] r;
    logic       we;
    logic       sf;
    logic       zf;
    logic       cf;
  } vec_t;

  localparam int NV = 20;
  // runs in order; carry flows from one row into the next
  localparam vec_t TBL [NV] = '{
    '{4'd0,  1'b0, 8'h10, 8'h20, 8'h00, 8'h30, 1'b1, 1'b0, 1'b0, 1'b0}, // ADD reg
    '{4'd0,  1'b1, 8'hF0, 8'h55, 8'h20, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1}, // ADD imm, carry out
    '{4'd1,  1'b0, 8'h01, 8'h01, 8'h00, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0}, // ADC cin=1
    '{4'd1,  1'b1, 8'hFF, 8'h12, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}, // ADC imm cin=0
    '{4'd2,  1'b0, 8'h05, 8'h06, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1}, // SUB borrow
    '{4'd1,  1'b0, 8'h7F, 8'h80, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1}, // ADC wrap to 0
    '{4'd7,  1'b0, 8'hF0, 8'h0F, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1}, // AND keeps C
    '{4'd3,  1'b1, 8'h10, 8'h00, 8'h0F, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}, // SUBC cin=1
    '{4'd3,  1'b0, 8'h00, 8'hFF, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1}, // SUBC borrow
    '{4'd3,  1'b0, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1}, // SUBC pending borrow
    '{4'd4,  1'b1, 8'h40, 8'h00, 8'h40, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // CP equal
    '{4'd4,  1'b0, 8'h20, 8'h30, 8'h00, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b1}, // CP borrow
    '{4'd8,  1'b1, 8'h81, 8'h00, 8'h80, 8'h80, 1'b0, 1'b1, 1'b0, 1'b1}, // TM
    '{4'd9,  1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1}, // OR
    '{4'd10, 1'b1, 8'hAA, 8'h00, 8'hAA, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1}, // XOR imm
    '{4'd5,  1'b1, 8'hFF, 8'h33, 8'h77, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1}, // INC wrap, operands ignored
    '{4'd5,  1'b0, 8'h7F, 8'h44, 8'h00, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0}, // INC
    '{4'd6,  1'b1, 8'h00, 8'h01, 8'h09, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1}, // DEC wrap
    '{4'd6,  1'b0, 8'h01, 8'hEE, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}, // DEC
    '{4'd10, 1'b0, 8'h0F, 8'hF0, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}  // XOR reg
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic       use_imm = 1'b0;
  logic [7:0] dest_val = '0, src_val = '0, imm_val = '0;
  logic [7:0] res_o;
  logic       wr_en_o, sign_o, zero_o, carry_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rs_alu u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .use_imm  (use_imm),
    .dest_val (dest_val),
    .src_val  (src_val),
    .imm_val  (imm_val),
    .res_o    (res_o),
    .wr_en_o  (wr_en_o),
    .sign_o   (sign_o),
    .zero_o   (zero_o),
    .carry_o  (carry_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string res_tag(input vec_t v);
    if (v.op == 4'd5 || v.op == 4'd6) return "R2 inc/dec result";
    if (v.imm)                        return "R2 imm result";
    return "R1 result";
  endfunction

  function automatic string cry_tag(input logic [3:0] op);
    if (op == 4'd5 || op == 4'd6)                  return "R7 carry";
    if (op == 4'd7 || op == 4'd8 || op >= 4'd9)    return "R8 carry";
    return "R6 carry";
  endfunction

  task automatic apply(input logic [3:0] op, input logic im,
                       input logic [7:0] d, input logic [7:0] s, input logic [7:0] i);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; use_imm = im;
    dest_val = d; src_val = s; imm_val = i;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " res"},   res_o,          8'h00);
    check({tag, " we"},    {7'd0, wr_en_o}, 8'd0);
    check({tag, " sign"},  {7'd0, sign_o},  8'd0);
    check({tag, " zero"},  {7'd0, zero_o},  8'd1);
    check({tag, " carry"}, {7'd0, carry_o}, 8'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R10 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R10 after release");

    for (int k = 0; k < NV; k++) begin
      apply(TBL[k].op, TBL[k].imm, TBL[k].d, TBL[k].s, TBL[k].i);
      check(res_tag(TBL[k]),      res_o,           TBL[k].r);
      check("R4 write strobe",     {7'd0, wr_en_o}, {7'd0, TBL[k].we});
      check("R5 sign",             {7'd0, sign_o},  {7'd0, TBL[k].sf});
      check("R5 zero",             {7'd0, zero_o},  {7'd0, TBL[k].zf});
      check(cry_tag(TBL[k].op),    {7'd0, carry_o}, {7'd0, TBL[k].cf});
    end

    // R3: strobe lasts one cycle, result held while idle
    apply(4'd0, 1'b0, 8'h01, 8'h02, 8'h00);
    check("R3 strobe on", {7'd0, wr_en_o}, 8'd1);
    @(negedge clk);
    check("R3 strobe off", {7'd0, wr_en_o}, 8'd0);
    check("R3 result held", res_o, 8'h03);

    // R9: illegal codes change nothing (carry set first)
    apply(4'd2, 1'b0, 8'h00, 8'h01, 8'h00);
    check("R6 setup borrow", {7'd0, carry_o}, 8'd1);
    for (int c = 11; c < 16; c++) begin
      apply(4'(c), 1'b0, 8'h00, 8'h00, 8'h00);
      check("R9 illegal res",   res_o,           8'hFF);
      check("R9 illegal we",    {7'd0, wr_en_o}, 8'd0);
      check("R9 illegal carry", {7'd0, carry_o}, 8'd1);
      check("R9 illegal zero",  {7'd0, zero_o},  8'd0);
      check("R9 illegal sign",  {7'd0, sign_o},  8'd1);
    end

    // R10: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("R10 async");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R10 rerelease");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule